// File: doc/BRIEF.md
# Parallel Multi-Lane LED Waveform Generator

This block drives up to sixteen single-wire addressable-LED data lines at the same time. All lines share one bit-slot counter, so every lane has the same edge timing. Each 60-cycle slot has three compare events. At the start of the slot, every enabled lane rises. At cycle 12, the lanes whose data bit is 0 fall. At cycle 31, every lane is low, which ends the long pulse that encodes a 1.

The data comes from an external bit-plane buffer. The block presents one read address per slot, and bit k of the returned lane-word is the bit for lane k. A frame works as follows:
- One idle slot comes first, with all lines low.
- Then come 24 data slots per LED.
- Then comes one more idle slot.
- Finally, a quiet guard interval of 2640 cycles (55 us at 48 MHz) gives the LEDs time to latch.

After the guard interval, a done flag rises. Software or a neighbouring engine fills the buffer, pulses start with an LED count and a lane-enable mask, and waits for done.

The control is a five-state sequencer with these states:
- S_IDLE: waiting for start.
- S_LEAD: the leading idle slot.
- S_DATA: the data slots.
- S_TRAIL: the trailing idle slot.
- S_GUARD: the latch guard interval.

Its transitions are:
- IDLE→LEAD: start is accepted.
- LEAD→DATA: the lead slot ends and the LED count is non-zero.
- LEAD→TRAIL: the lead slot ends and the LED count is zero.
- DATA→TRAIL: the last data slot ends.
- TRAIL→GUARD: the trail slot ends.
- GUARD→IDLE: the guard count expires, and done is set.

Top module: `ledwave_top`

## Requirements
- R1: Every data slot is 60 cycles long. On each enabled lane, every data slot produces exactly one high pulse, and that pulse rises on the first cycle of the slot.
- R2: A data bit of 0 gives a high time of 12 cycles.
- R3: A data bit of 1 gives a high time of 31 cycles. After that the lane stays low for the rest of the slot.
- R4: A lane whose bit is clear in the enable mask captured at start stays low for the whole frame.
- R5: Data slot j reads buffer address j, for j from 0 to 24·N−1.
  - `rd_addr_o` holds j for the whole slot.
  - `rd_data_i` is sampled on slot cycle 11, so the buffer may take up to 10 cycles to answer.
  - Bit k of the word drives lane k.
- R6: The frame has one all-low idle slot before the data slots and one after them. Counting from the first cycle in which `busy_o` is high, the first data pulse appears 61 cycles later.
- R7: `busy_o` stays high for exactly 60·(24·N+2)+2640 cycles. In the cycle after that, `busy_o` is low and `done_o` is high, and all lanes are low through the whole guard interval.
- R8: A start pulse while `busy_o` is high is ignored. The LED count and the enable mask are captured only when a start is accepted, so changing them during a frame has no effect on that frame.
- R9: Reset state:
  - All lanes are low.
  - `busy_o` and `done_o` are low.
  - `rd_addr_o` is 0.
  - `done_o` stays high from the end of a frame until the next accepted start, and clears together with the rise of `busy_o`.
- R10: An LED count of 0 produces a frame with no pulses on any lane. That frame lasts 60·2+2640 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (48 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse; accepted only when idle |
| led_count_i | input | 8 | LEDs per lane for the next frame |
| lane_en_i | input | 16 | Lane enable mask for the next frame |
| rd_data_i | input | 16 | Lane-word from the bit-plane buffer |
| lane_o | output | 16 | LED data lines |
| rd_addr_o | output | 13 | Bit-plane buffer read address |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | Last frame finished, including the guard interval |

## Verification
All timing is measured from the first sample in which `busy_o` is high, which is relative cycle 0.

- **Lane pins:** the pins are registered from the slot counter, so the value for data slot j at tick t is due at relative cycle 61+60·j+t. The bench samples every cycle on the falling clock edge and compares each lane against a value computed from its own copy of the buffer contents, at exactly that offset.
- **Read address:** the address is checked at relative cycle 71+60·j, which is slot tick 11.
- **End of frame:** busy is expected to fall, and done to rise, at relative cycle 60·(24·N+2)+2640.
- **Ignored inputs:** a start pulse and changed count and mask inputs injected mid-frame must leave both the per-cycle pin trace and the frame length unchanged.

// File: rtl/ledwave_pkg.sv
package ledwave_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_LEAD  = 3'd1,
        S_DATA  = 3'd2,
        S_TRAIL = 3'd3,
        S_GUARD = 3'd4
    } wave_state_e;

endpackage

// File: rtl/ledwave_slot_timer.sv
module ledwave_slot_timer #(
    parameter int TICKS  = 60,
    parameter int TICK_W = $clog2(TICKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    output logic [TICK_W-1:0] tick_o,
    output logic              slot_end_o
);

    localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(TICKS - 1);

    logic [TICK_W-1:0] tick_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= '0;
        end else if (!run_i) begin
            tick_q <= '0;
        end else if (tick_q == LAST_TICK) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    assign tick_o     = tick_q;
    assign slot_end_o = run_i && (tick_q == LAST_TICK);

    // R1: a running slot always wraps back to tick zero after its last tick
    p_tick_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_q == LAST_TICK) |=> (tick_q == '0));

endmodule

// File: rtl/ledwave_frame_fsm.sv
module ledwave_frame_fsm
    import ledwave_pkg::*;
#(
    parameter int LANES        = 16,
    parameter int LEDS_W       = 8,
    parameter int BITS_PER_LED = 24,
    parameter int LEAD_SLOTS   = 1,
    parameter int TRAIL_SLOTS  = 1,
    parameter int GUARD_TICKS  = 2640,
    parameter int ADDR_W       = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LEDS_W-1:0] led_count_i,
    input  logic [LANES-1:0]  lane_en_i,
    input  logic              slot_end_i,
    output wave_state_e       state_o,
    output logic [LANES-1:0]  lane_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam int PAD_MAX = (LEAD_SLOTS > TRAIL_SLOTS) ? LEAD_SLOTS : TRAIL_SLOTS;
    localparam int PAD_W   = $clog2(PAD_MAX + 1);
    localparam int GUARD_W = $clog2(GUARD_TICKS + 1);
    localparam logic [PAD_W-1:0]   LEAD_LAST  = PAD_W'(LEAD_SLOTS - 1);
    localparam logic [PAD_W-1:0]   TRAIL_LAST = PAD_W'(TRAIL_SLOTS - 1);
    localparam logic [GUARD_W-1:0] GUARD_LAST = GUARD_W'(GUARD_TICKS - 1);

    wave_state_e        state_q, state_d;
    logic [PAD_W-1:0]   pad_q;
    logic [GUARD_W-1:0] guard_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [ADDR_W-1:0]  last_q;
    logic               empty_q;
    logic [LANES-1:0]   en_q;
    logic               done_q;
    logic               accept;

    assign accept = (state_q == S_IDLE) && start_i;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) state_d = S_LEAD;
            end
            S_LEAD: begin
                if (slot_end_i && pad_q == LEAD_LAST)
                    state_d = empty_q ? S_TRAIL : S_DATA;
            end
            S_DATA: begin
                if (slot_end_i && addr_q == last_q) state_d = S_TRAIL;
            end
            S_TRAIL: begin
                if (slot_end_i && pad_q == TRAIL_LAST) state_d = S_GUARD;
            end
            S_GUARD: begin
                if (guard_q == GUARD_LAST) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // frame counters and captured settings
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pad_q   <= '0;
            guard_q <= '0;
            addr_q  <= '0;
            last_q  <= '0;
            empty_q <= 1'b1;
            en_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            if (state_d != state_q) begin
                pad_q <= '0;
            end else if (slot_end_i && (state_q == S_LEAD || state_q == S_TRAIL)) begin
                pad_q <= pad_q + 1'b1;
            end

            if (state_q == S_GUARD) guard_q <= guard_q + 1'b1;
            else                    guard_q <= '0;

            if (accept) begin
                addr_q  <= '0;
                last_q  <= ADDR_W'(led_count_i) * ADDR_W'(BITS_PER_LED) - ADDR_W'(1);
                empty_q <= (led_count_i == '0);
                en_q    <= lane_en_i;
                done_q  <= 1'b0;
            end else begin
                if (state_q == S_DATA && slot_end_i && addr_q != last_q)
                    addr_q <= addr_q + 1'b1;
                if (state_q == S_GUARD && guard_q == GUARD_LAST)
                    done_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        state_o   = state_q;
        lane_en_o = en_q;
        rd_addr_o = addr_q;
        busy_o    = (state_q != S_IDLE);
        done_o    = done_q;
    end

    // R5: the read address holds for the whole of a data slot
    p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DATA && !slot_end_i) |=> $stable(addr_q));

    // R8: a start while busy leaves the captured frame settings untouched
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(en_q) && $stable(last_q) && $stable(empty_q)));

    // R9: done and busy never overlap
    p_done_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R7: leaving the guard interval always raises done
    p_guard_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_GUARD && state_d == S_IDLE) |=> done_o);

endmodule

// File: rtl/ledwave_lane_shaper.sv
module ledwave_lane_shaper #(
    parameter int LANES  = 16,
    parameter int TICKS  = 60,
    parameter int T0     = 12,
    parameter int T1     = 31,
    parameter int TICK_W = $clog2(TICKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_slot_i,
    input  logic [TICK_W-1:0] tick_i,
    input  logic [LANES-1:0]  rd_data_i,
    input  logic [LANES-1:0]  lane_en_i,
    output logic [LANES-1:0]  lane_o
);

    localparam logic [TICK_W-1:0] T0_T     = TICK_W'(T0);
    localparam logic [TICK_W-1:0] T1_T     = TICK_W'(T1);
    localparam logic [TICK_W-1:0] SAMPLE_T = TICK_W'(T0 - 1);

    logic [LANES-1:0] word_q;
    logic             early;
    logic             mid;

    assign early = data_slot_i && (tick_i < T0_T);
    assign mid   = data_slot_i && (tick_i < T1_T);

    // lane-word capture one tick before the zero-bit edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (data_slot_i && tick_i == SAMPLE_T) begin
            word_q <= rd_data_i;
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic pin_q;
        always_ff @(posedge clk) begin
            if (!rst_n) pin_q <= 1'b0;
            else        pin_q <= lane_en_i[k] & (early | (mid & word_q[k]));
        end
        assign lane_o[k] = pin_q;
    end

    // R1: a lane can only rise right after tick zero of a slot
    p_rise_slot_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|(lane_o & ~$past(lane_o))) |-> ($past(tick_i) == '0));

    // R3: after the late edge every lane is low for the rest of the slot
    p_low_after_cutoff_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i > T1_T) |-> (lane_o == '0));

    // R4: masked lanes are never driven
    p_masked_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_o & ~lane_en_i) == '0);

endmodule

// File: rtl/ledwave_top.sv
module ledwave_top
    import ledwave_pkg::*;
#(
    parameter int LANES        = 16,
    parameter int LEDS_W       = 8,
    parameter int BITS_PER_LED = 24,
    parameter int TICKS        = 60,
    parameter int T0           = 12,
    parameter int T1           = 31,
    parameter int LEAD_SLOTS   = 1,
    parameter int TRAIL_SLOTS  = 1,
    parameter int GUARD_TICKS  = 2640,
    localparam int MAX_BITS    = ((1 << LEDS_W) - 1) * BITS_PER_LED,
    localparam int ADDR_W      = $clog2(MAX_BITS),
    localparam int TICK_W      = $clog2(TICKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LEDS_W-1:0] led_count_i,
    input  logic [LANES-1:0]  lane_en_i,
    input  logic [LANES-1:0]  rd_data_i,
    output logic [LANES-1:0]  lane_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              busy_o,
    output logic              done_o
);

    wave_state_e       state;
    logic [LANES-1:0]  en_cap;
    logic [TICK_W-1:0] tick;
    logic              slot_end;
    logic              run;
    logic              data_slot;

    assign run       = (state == S_LEAD) || (state == S_DATA) || (state == S_TRAIL);
    assign data_slot = (state == S_DATA);

    ledwave_slot_timer #(
        .TICKS (TICKS),
        .TICK_W(TICK_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .tick_o    (tick),
        .slot_end_o(slot_end)
    );

    ledwave_frame_fsm #(
        .LANES       (LANES),
        .LEDS_W      (LEDS_W),
        .BITS_PER_LED(BITS_PER_LED),
        .LEAD_SLOTS  (LEAD_SLOTS),
        .TRAIL_SLOTS (TRAIL_SLOTS),
        .GUARD_TICKS (GUARD_TICKS),
        .ADDR_W      (ADDR_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .led_count_i(led_count_i),
        .lane_en_i  (lane_en_i),
        .slot_end_i (slot_end),
        .state_o    (state),
        .lane_en_o  (en_cap),
        .rd_addr_o  (rd_addr_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    ledwave_lane_shaper #(
        .LANES (LANES),
        .TICKS (TICKS),
        .T0    (T0),
        .T1    (T1),
        .TICK_W(TICK_W)
    ) u_shaper (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_slot_i(data_slot),
        .tick_i     (tick),
        .rd_data_i  (rd_data_i),
        .lane_en_i  (en_cap),
        .lane_o     (lane_o)
    );

    // R7: the lines are quiet whenever the previous cycle was outside a data slot
    p_quiet_outside_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_DATA) |=> (lane_o == '0));

endmodule

// File: tb/tb_ledwave_top.sv
module tb_ledwave_top;

    localparam int CLK_PERIOD = 10;
    localparam int LANES = 16;
    localparam int TICKS = 60;
    localparam int T0    = 12;
    localparam int T1    = 31;
    localparam int BPL   = 24;
    localparam int PAD   = 1;
    localparam int GUARD = 2640;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [7:0]  led_count;
    logic [15:0] lane_en;
    logic [15:0] rd_data;
    logic [15:0] lane;
    logic [12:0] rd_addr;
    logic        busy;
    logic        done;

    logic [15:0] mem [0:127];
    int total = 0;
    int bad   = 0;
    bit ended = 0;

    ledwave_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .led_count_i(led_count),
        .lane_en_i  (lane_en),
        .rd_data_i  (rd_data),
        .lane_o     (lane),
        .rd_addr_o  (rd_addr),
        .busy_o     (busy),
        .done_o     (done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // bit-plane buffer model, one cycle read latency
    always_ff @(posedge clk) rd_data <= mem[rd_addr[6:0]];

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_pins(int rel, int n, logic [15:0] en);
        int q = rel - 1 - TICKS * PAD;
        int j, t;
        if (q < 0 || q >= TICKS * BPL * n) return 16'h0;
        j = q / TICKS;
        t = q % TICKS;
        if (t < T0) return en;
        if (t < T1) return en & mem[j];
        return 16'h0;
    endfunction

    task automatic run_frame(int n, logic [15:0] en, bit perturb);
        int s_exp = TICKS * (BPL * n + 2 * PAD) + GUARD;
        int e1 = 0, e2 = 0, e3 = 0, e4 = 0, e6 = 0, ea = 0;
        int rel = 0;
        logic [15:0] act, ex;
        @(negedge clk);
        start = 1'b1; led_count = 8'(n); lane_en = en;
        @(negedge clk);
        start = 1'b0;
        check(busy && !done, "R9", "busy/done after start", {busy, done}, 2);
        while (busy && rel < s_exp + 50) begin
            act = lane;
            ex  = exp_pins(rel, n, en);
            for (int k = 0; k < LANES; k++) begin
                if (act[k] !== ex[k]) begin
                    int q = rel - 1 - TICKS * PAD;
                    if (!en[k]) e4++;
                    else if (q < 0 || q >= TICKS * BPL * n) e6++;
                    else if ((q % TICKS) < T0) e1++;
                    else if (mem[q / TICKS][k]) e3++;
                    else e2++;
                end
            end
            begin
                int r2 = rel - TICKS * PAD;
                if (r2 >= 0 && r2 < TICKS * BPL * n && (r2 % TICKS) == T0 - 1)
                    if (int'(rd_addr) != r2 / TICKS) ea++;
            end
            if (perturb && rel == 300) begin
                start = 1'b1; led_count = 8'(n + 1); lane_en = ~en;
            end
            if (perturb && rel == 301) start = 1'b0;
            @(negedge clk);
            rel++;
        end
        check(rel == s_exp, "R7", "busy length", rel, s_exp);
        check(done == 1'b1, "R7", "done after guard", int'(done), 1);
        check(e1 == 0, "R1", "slot start / early region mismatches", e1, 0);
        check(e6 == 0, n == 0 ? "R10" : "R6", "idle slot mismatches", e6, 0);
        if (n > 0) begin
            check(e2 == 0, "R2", "zero-bit pulse mismatches", e2, 0);
            check(e3 == 0, "R3", "one-bit pulse mismatches", e3, 0);
            check(ea == 0, "R5", "read address mismatches", ea, 0);
        end
        if (en != 16'hFFFF) check(e4 == 0, "R4", "masked lane activity", e4, 0);
        if (perturb) check(e1 + e2 + e3 + e4 + e6 == 0 && rel == s_exp, "R8",
                           "frame disturbed by mid-frame inputs", e1 + e2 + e3 + e4 + e6, 0);
        repeat (5) @(negedge clk);
        check(done && !busy && lane == 16'h0, "R9", "done held while idle",
              {done, busy}, 2);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!ended) begin
            total++; bad++;
            $display("FAIL R7 watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; start = 1'b0; led_count = 8'd0; lane_en = 16'h0;
        for (int i = 0; i < 128; i++) mem[i] = 16'h0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(lane == 16'h0, "R9", "reset lanes", int'(lane), 0);
        check(!busy && !done, "R9", "reset busy/done", {busy, done}, 0);
        check(rd_addr == 13'd0, "R9", "reset address", int'(rd_addr), 0);

        // all one bits on every lane (R3)
        for (int i = 0; i < 128; i++) mem[i] = 16'hFFFF;
        run_frame(1, 16'hFFFF, 1'b0);
        // all zero bits on every lane (R2)
        for (int i = 0; i < 128; i++) mem[i] = 16'h0000;
        run_frame(1, 16'hFFFF, 1'b0);
        // empty frame (R10)
        run_frame(0, 16'hFFFF, 1'b0);
        // lane mapping and masking with a walking pattern (R4, R5)
        for (int i = 0; i < 128; i++) mem[i] = 16'h1 << (i % 16);
        run_frame(2, 16'h8421, 1'b0);
        // random frames
        for (int f = 0; f < 3; f++) begin
            for (int i = 0; i < 128; i++) mem[i] = 16'($urandom);
            run_frame(1 + int'($urandom % 3), 16'($urandom), 1'b0);
        end
        // mid-frame start and setting changes (R8)
        for (int i = 0; i < 128; i++) mem[i] = 16'($urandom);
        run_frame(2, 16'h5AF0, 1'b1);

        ended = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule